// File: doc/BRIEF.md
# Index Queue with Memory Spill and Tail-to-Head Bypass

This block is a first-in-first-out queue of buffer indexes. It is built from a four-entry tail stage that takes pushes, a four-entry head stage that serves pops, and a circular region of external memory between them. Entries move into memory only as whole lines of four indexes. While that region is empty, indexes skip it and move from the tail to the head one per cycle over an internal path. The head is refilled with one four-index line whenever it runs dry and memory still holds lines.

A configuration input, `force_mem`, turns the direct path off, so that every index passes through memory. Only full lines are written. With the path off, up to three indexes can therefore stay in the tail, and pops return the null pointer even though indexes are still queued. The index value zero is reserved as that null pointer and is never pushed. The memory port has a write strobe with a line address and a line of data, and a read strobe with a line address. Read data is expected one cycle after the read strobe.

Top module: `index_spill_queue`

## Requirements
- R1: After reset `push_ready` is 1, `pop_idx` is 0, and neither `mem_wr_en` nor `mem_rd_en` is asserted.
- R2: With `force_mem` low and no lines in memory, an index accepted at clock edge k reaches `pop_idx` after edge k+1, and `pop_idx` is still 0 between the two edges.
- R3: Indexes leave in the order they were pushed, including when some of them were spilled to memory.
- R4: With `force_mem` high the head gains entries only from memory reads, and indexes left in a tail that is not full never reach `pop_idx`. They are released once `force_mem` goes low while memory is empty.
- R5: A memory write carries exactly four queued indexes, the oldest in bits [15:0] and the newest in bits [63:48]. A tail holding fewer than four indexes causes no write.
- R6: When the head is empty and memory holds at least one line, a read of the oldest line is issued, and the head is loaded with that line on the second edge after the read strobe.
- R7: `push_ready` is 0 while the tail holds four indexes, and a push offered in that state is not accepted.
- R8: A pop that finds the head empty returns 0 and removes nothing.
- R9: Memory line addresses wrap from MEM_LINES-1 to 0, and no write is issued while all MEM_LINES lines are occupied.
- R10: A push, a pop and a tail-to-head move may all take effect in the same cycle without losing or reordering any index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_mem | input | 1 | 1 disables the tail-to-head path so that every index goes through memory |
| push_valid | input | 1 | Offer an index |
| push_idx | input | IDX_W | Index offered (never 0) |
| push_ready | output | 1 | Tail can accept an index this cycle |
| pop_req | input | 1 | Remove the head index at this edge |
| pop_idx | output | IDX_W | Current head index, 0 when the head is empty |
| mem_wr_en | output | 1 | Write one line to memory |
| mem_wr_addr | output | AW | Line address of the write |
| mem_wr_line | output | GRP*IDX_W | Four indexes, oldest in the lowest lane |
| mem_rd_en | output | 1 | Read one line from memory |
| mem_rd_addr | output | AW | Line address of the read |
| mem_rd_line | input | GRP*IDX_W | Read data, valid one cycle after `mem_rd_en` |

## Verification
Two pairs of events can fall in the same cycle. A pop at the head can coincide with a tail-to-head move that appends behind it. A memory write that drains the tail can coincide with a read that refills the head. The first pair is provoked by pushing and popping in every cycle while the head holds one entry, and each returned index is compared with a queue kept in the bench. The second pair arises when the memory region is filled and then drained, and it is judged by whether the bench receives the full pushed sequence back in order across a line-address wrap.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // next line slot in a circular region of `lines` lines
  function automatic int unsigned line_step(input int unsigned p, input int unsigned lines);
    return (p + 1 == lines) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle with an optional add and an optional remove
  function automatic int unsigned fill_after(input int unsigned c, input bit inc, input bit dec);
    return c + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction
endpackage

// File: rtl/iq_tail.sv
module iq_tail #(
  parameter int IDX_W = 16,
  parameter int GRP   = 4,
  parameter int CW    = $clog2(GRP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_fire,
  input  logic [IDX_W-1:0]     push_idx,
  input  logic                 take_one,
  input  logic                 take_all,
  output logic [CW-1:0]        cnt,
  output logic [GRP*IDX_W-1:0] line
);
  logic [IDX_W-1:0] ent [GRP];
  logic [IDX_W-1:0] nxt [GRP];
  logic [CW-1:0]    n;

  always_comb begin
    nxt = ent;
    n   = cnt;
    if (take_all) begin
      n = '0;
    end else if (take_one) begin
      for (int i = 0; i < GRP - 1; i++) nxt[i] = ent[i+1];
      n = cnt - CW'(1);
    end
    if (push_fire) begin
      for (int i = 0; i < GRP; i++) if (CW'(i) == n) nxt[i] = push_idx;
      n = n + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < GRP; i++) ent[i] <= '0;
    end else begin
      cnt <= n;
      ent <= nxt;
    end
  end

  for (genvar g = 0; g < GRP; g++) begin : g_lane
    assign line[g*IDX_W +: IDX_W] = ent[g];
  end

  // R7: a full tail never takes a push
  assert_no_push_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(GRP)) |-> !push_fire);
  assert_tail_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(GRP));
endmodule

// File: rtl/iq_head.sv
module iq_head #(
  parameter int IDX_W = 16,
  parameter int GRP   = 4,
  parameter int CW    = $clog2(GRP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pop_fire,
  input  logic                 byp_fire,
  input  logic [IDX_W-1:0]     byp_idx,
  input  logic                 load,
  input  logic [GRP*IDX_W-1:0] load_line,
  output logic [CW-1:0]        cnt,
  output logic [IDX_W-1:0]     front
);
  logic [IDX_W-1:0] ent [GRP];
  logic [IDX_W-1:0] nxt [GRP];
  logic [CW-1:0]    n;

  always_comb begin
    nxt = ent;
    n   = cnt;
    if (pop_fire) begin
      for (int i = 0; i < GRP - 1; i++) nxt[i] = ent[i+1];
      n = cnt - CW'(1);
    end
    if (byp_fire) begin
      for (int i = 0; i < GRP; i++) if (CW'(i) == n) nxt[i] = byp_idx;
      n = n + CW'(1);
    end
    if (load) begin
      for (int i = 0; i < GRP; i++) nxt[i] = load_line[i*IDX_W +: IDX_W];
      n = CW'(GRP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < GRP; i++) ent[i] <= '0;
    end else begin
      cnt <= n;
      ent <= nxt;
    end
  end

  assign front = (cnt != '0) ? ent[0] : '0;

  // R6: a memory line only lands in an empty head
  assert_load_into_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));
  // R2: a tail-to-head move leaves the head non-empty
  assert_bypass_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byp_fire |=> (cnt != '0));
endmodule

// File: rtl/iq_spill.sv
module iq_spill
  import iq_pkg::*;
#(
  parameter int MEM_LINES = 4,
  parameter int AW        = $clog2(MEM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tail_full,
  input  logic          head_empty,
  input  logic          byp_mv,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          load,
  output logic          mem_idle
);
  localparam int MCW = $clog2(MEM_LINES + 1);

  logic [MCW-1:0] mcnt;
  logic           rd_pend;

  assign wr_en    = tail_full && !byp_mv && (mcnt != MCW'(MEM_LINES));
  assign rd_en    = head_empty && (mcnt != '0) && !rd_pend;
  assign load     = rd_pend;
  assign mem_idle = (mcnt == '0) && !rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      mcnt    <= '0;
      rd_pend <= 1'b0;
    end else begin
      if (wr_en) wr_addr <= AW'(line_step(wr_addr, MEM_LINES));
      if (rd_en) rd_addr <= AW'(line_step(rd_addr, MEM_LINES));
      mcnt    <= MCW'(fill_after(mcnt, wr_en, rd_en));
      rd_pend <= rd_en;
    end
  end

  // R9: occupancy bounded, addresses wrap to zero
  assert_mem_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt <= MCW'(MEM_LINES));
  assert_wr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(MEM_LINES - 1)) |=> (wr_addr == '0));
  // R6: a read strobe is followed by a head load
  assert_read_then_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> load);
endmodule

// File: rtl/index_spill_queue.sv
module index_spill_queue #(
  parameter int IDX_W     = 16,
  parameter int GRP       = 4,
  parameter int MEM_LINES = 4,
  parameter int AW        = $clog2(MEM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 force_mem,
  input  logic                 push_valid,
  input  logic [IDX_W-1:0]     push_idx,
  output logic                 push_ready,
  input  logic                 pop_req,
  output logic [IDX_W-1:0]     pop_idx,
  output logic                 mem_wr_en,
  output logic [AW-1:0]        mem_wr_addr,
  output logic [GRP*IDX_W-1:0] mem_wr_line,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [GRP*IDX_W-1:0] mem_rd_line
);
  localparam int CW = $clog2(GRP + 1);

  logic [CW-1:0] tcnt, hcnt;
  logic          push_fire, pop_fire, byp_mv, head_room;
  logic          spill_load, mem_idle;

  assign push_ready = (tcnt != CW'(GRP));
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_req && (hcnt != '0);
  assign head_room  = (hcnt != CW'(GRP)) || pop_fire;
  assign byp_mv     = !force_mem && mem_idle && (tcnt != '0) && head_room;

  iq_tail #(.IDX_W(IDX_W), .GRP(GRP), .CW(CW)) u_tail (
    .clk(clk), .rst_n(rst_n), .push_fire(push_fire), .push_idx(push_idx),
    .take_one(byp_mv), .take_all(mem_wr_en), .cnt(tcnt), .line(mem_wr_line));

  iq_head #(.IDX_W(IDX_W), .GRP(GRP), .CW(CW)) u_head (
    .clk(clk), .rst_n(rst_n), .pop_fire(pop_fire), .byp_fire(byp_mv),
    .byp_idx(mem_wr_line[IDX_W-1:0]), .load(spill_load), .load_line(mem_rd_line),
    .cnt(hcnt), .front(pop_idx));

  iq_spill #(.MEM_LINES(MEM_LINES), .AW(AW)) u_spill (
    .clk(clk), .rst_n(rst_n), .tail_full(tcnt == CW'(GRP)), .head_empty(hcnt == '0),
    .byp_mv(byp_mv), .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .rd_en(mem_rd_en),
    .rd_addr(mem_rd_addr), .load(spill_load), .mem_idle(mem_idle));

  // R4: with the path off the head only grows through memory loads
  assert_force_no_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_mem && !spill_load) |=> (hcnt <= $past(hcnt)));
  // R5: a line write drains the whole tail
  assert_write_drains_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (tcnt == '0));
  // R10: a pop and a move in one cycle keep the head count
  assert_pop_and_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && byp_mv && !spill_load) |=> (hcnt == $past(hcnt)));
endmodule

// File: tb/index_spill_queue_test.sv
module index_spill_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;
  localparam int GRP = 4;
  localparam int ML = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_mem = 1'b0;
  logic push_valid = 1'b0;
  logic [IW-1:0] push_idx = '0;
  logic push_ready;
  logic pop_req = 1'b0;
  logic [IW-1:0] pop_idx;
  logic mem_wr_en, mem_rd_en;
  logic [AW-1:0] mem_wr_addr, mem_rd_addr;
  logic [GRP*IW-1:0] mem_wr_line;
  logic [GRP*IW-1:0] mem_rd_line = '0;
  logic [GRP*IW-1:0] mem [ML];

  int checks = 0;
  int fails = 0;
  int wr_count = 0;
  int rd_count = 0;
  logic [IW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  index_spill_queue #(.IDX_W(IW), .GRP(GRP), .MEM_LINES(ML), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .force_mem(force_mem), .push_valid(push_valid),
    .push_idx(push_idx), .push_ready(push_ready), .pop_req(pop_req), .pop_idx(pop_idx),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_line(mem_wr_line),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_line(mem_rd_line));

  // backing memory: one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_line;
    if (mem_rd_en) mem_rd_line <= mem[mem_rd_addr];
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // write monitor, sampled between edges
  always @(negedge clk) begin
    if (rst_n && mem_rd_en) rd_count++;
    if (rst_n && mem_wr_en) begin
      wr_count++;
      for (int i = 0; i < GRP; i++)
        check(mem_wr_line[i*IW +: IW] != '0, "R5", "write lane empty", 0, 1);
    end
  end

  task automatic push(input logic [IW-1:0] v);
    @(negedge clk);
    while (!push_ready) @(negedge clk);
    push_valid = 1'b1;
    push_idx = v;
    exp_q.push_back(v);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // call at a negedge; waits for a head entry, compares, pops
  task automatic pop_chk(input string req);
    int w = 0;
    logic [IW-1:0] e;
    while (pop_idx == '0 && w < 16) begin
      @(negedge clk);
      w++;
    end
    e = exp_q.pop_front();
    check(pop_idx == e, req, "popped index", int'(pop_idx), int'(e));
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(push_ready == 1'b1, "R1", "push_ready", int'(push_ready), 1);
    check(pop_idx == '0, "R1", "pop_idx", int'(pop_idx), 0);
    check(!mem_wr_en && !mem_rd_en, "R1", "mem strobes", int'({mem_wr_en, mem_rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bypass();
    push(16'h0005);
    check(pop_idx == '0, "R2", "head before move", int'(pop_idx), 0);
    @(negedge clk);
    check(pop_idx == 16'h0005, "R2", "head after move", int'(pop_idx), 5);
    pop_chk("R2");
    check(pop_idx == '0, "R8", "empty after drain", int'(pop_idx), 0);
  endtask

  task automatic t_same_cycle();
    int w0 = wr_count;
    logic [IW-1:0] e;
    push(16'h0011);
    push(16'h0012);
    for (int k = 0; k < 6; k++) begin
      e = exp_q.pop_front();
      check(pop_idx == e, "R10", "pop during push", int'(pop_idx), int'(e));
      push_valid = 1'b1;
      push_idx = IW'(16'h0020 + k);
      exp_q.push_back(push_idx);
      pop_req = 1'b1;
      @(negedge clk);
    end
    push_valid = 1'b0;
    pop_req = 1'b0;
    check(wr_count == w0, "R10", "no spill while streaming", wr_count - w0, 0);
    while (exp_q.size() != 0) pop_chk("R10");
  endtask

  task automatic t_spill();
    int w0 = wr_count;
    int r0 = rd_count;
    for (int k = 1; k <= 12; k++) push(IW'(16'h0100 + k));
    repeat (2) @(negedge clk);
    check(wr_count - w0 == 2, "R5", "line writes", wr_count - w0, 2);
    check(mem[0][IW-1:0] == 16'h0105, "R5", "oldest lane low", int'(mem[0][IW-1:0]), 16'h0105);
    check(mem[0][4*IW-1 -: IW] == 16'h0108, "R5", "newest lane high", int'(mem[0][4*IW-1 -: IW]), 16'h0108);
    while (exp_q.size() != 0) pop_chk("R3");
    check(rd_count - r0 == 2, "R6", "line reads", rd_count - r0, 2);
    @(negedge clk);
    pop_req = 1'b1;
    check(pop_idx == '0, "R8", "pop on empty", int'(pop_idx), 0);
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic t_force();
    int w0 = wr_count;
    force_mem = 1'b1;
    for (int k = 0; k < 6; k++) push(IW'(16'h0050 + k));
    for (int k = 0; k < 4; k++) pop_chk("R4");
    repeat (6) @(negedge clk);
    check(pop_idx == '0, "R4", "stranded residue", int'(pop_idx), 0);
    check(wr_count - w0 == 1, "R5", "partial tail not written", wr_count - w0, 1);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    check(pop_idx == '0, "R8", "empty pop result", int'(pop_idx), 0);
    force_mem = 1'b0;
    pop_chk("R8");
    pop_chk("R4");
  endtask

  task automatic t_full();
    int w0 = wr_count;
    for (int k = 0; k < 24; k++) push(IW'(16'h0200 + k));
    push_valid = 1'b1;
    push_idx = 16'h0300;
    repeat (8) @(negedge clk);
    check(push_ready == 1'b0, "R7", "ready when full", int'(push_ready), 0);
    check(wr_count - w0 == ML, "R9", "writes capped", wr_count - w0, ML);
    push_valid = 1'b0;
    while (exp_q.size() != 0) pop_chk("R9");
    repeat (4) @(negedge clk);
    check(pop_idx == '0, "R7", "refused push absent", int'(pop_idx), 0);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_same_cycle();
    t_spill();
    t_force();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule